// File: doc/BRIEF.md
# Memory Block Compare Engine

The engine checks whether two equal-length runs of words in memory hold the same data. A start pulse supplies the base address of each run and a word count. The engine then walks the two runs one pair at a time over a single memory read port. For each pair it fetches the word from run A first and the word from run B second. It stops at the first pair that differs. When it stops, it reports how many words were still outstanding, counting the differing pair itself. If every pair matches, it reports zero.

A pause request is checked once per pair, after a pair has compared equal and more pairs remain. When the request is taken, the engine stops with a suspended pulse. It then shows the addresses and count of the next pair on its resume outputs. Restarting with those three values continues the compare as if it had never stopped.

The read port is a valid/ready request channel followed by a valid/ready response channel. A request holds `rd_req_valid` and `rd_addr` steady until the memory accepts it with `rd_req_ready`, so the memory can apply back-pressure for any number of cycles. Only one read is outstanding at a time. The engine raises `rd_rsp_ready` while it waits and takes the word in the cycle in which `rd_rsp_valid` is high, so response latency may vary freely. Control and status pins are plain levels and pulses.

Top module: `blkcmp_engine`

## Requirements
- R1: Each pair is fetched as two reads in order: first from run A at address base_a+i, then from run B at address base_b+i, for pair index i = 0, 1, 2, ...
- R2: When all n_words pairs are equal, done pulses with mismatch=0 and remain=0. resume_a and resume_b then equal base_a+n_words and base_b+n_words, and resume_n is 0.
- R3: When pair k is the first unequal pair, done pulses with mismatch=1 and remain=n_words-k. No read is issued after the read of pair k from run B, and the resume outputs point at pair k.
- R4: A start with n_words=0 raises done (mismatch=0, remain=0) in the cycle after start is sampled and issues no read.
- R5: When pause_req is high as a pair compares equal and pairs remain, the engine pulses suspended instead of done. resume_a, resume_b and resume_n then give the next pair and the words left, and a start with those values produces the same final result as an uninterrupted compare.
- R6: pause_req has no effect on the final pair or on a mismatching pair: done is reported, not suspended.
- R7: rd_req_valid, once high, stays high with rd_addr unchanged until rd_req_ready. At most one read is outstanding, and any response latency is tolerated.
- R8: start is ignored while busy is high.
- R9: After reset, busy, done, suspended and rd_req_valid are 0. done and suspended are one-cycle pulses and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a compare (sampled only while idle) |
| base_a | input | AW | First address of run A |
| base_b | input | AW | First address of run B |
| n_words | input | CW | Number of word pairs to compare |
| pause_req | input | 1 | Request to stop after the current equal pair |
| busy | output | 1 | Compare in progress |
| done | output | 1 | One-cycle pulse: compare finished |
| mismatch | output | 1 | With done: an unequal pair was found |
| suspended | output | 1 | One-cycle pulse: stopped for a pause request |
| remain | output | CW | With done: words left from the mismatching pair, else 0 |
| resume_a | output | AW | Run A address of the next pair to compare |
| resume_b | output | AW | Run B address of the next pair to compare |
| resume_n | output | CW | Pairs still to compare |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_addr | output | AW | Read address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_ready | output | 1 | Engine waits for read data |
| rd_rsp_data | input | DW | Read data |

## Verification
The bench builds the engine with AW=8, DW=16 and CW=8. With these values a 256-word memory model covers the whole address space, and counts up to 255 can be represented. The memory model applies request stalls and response latencies of zero to three cycles, so the hold rule on the request and the wait for response data both come into play. Runs that are resumed repeatedly while pause_req is held high take the suspend path once per pair, with single-pair runs in between.

// File: rtl/blkcmp_pkg.sv
package blkcmp_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_ISSUE_A, SQ_WAIT_A, SQ_ISSUE_B, SQ_WAIT_B
  } seq_state_t;

  typedef enum logic [1:0] {
    RD_IDLE, RD_REQ, RD_RSP
  } rd_state_t;
endpackage

// File: rtl/blkcmp_reader.sv
module blkcmp_reader
  import blkcmp_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] go_addr,
  output logic          idle,
  output logic          word_vld,
  output logic [DW-1:0] word,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_rsp_valid,
  output logic          rd_rsp_ready,
  input  logic [DW-1:0] rd_rsp_data
);
  rd_state_t st;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= RD_IDLE;
      addr_q <= '0;
    end else begin
      case (st)
        RD_IDLE: if (go) begin
          addr_q <= go_addr;
          st     <= RD_REQ;
        end
        RD_REQ:  if (rd_req_ready) st <= RD_RSP;
        RD_RSP:  if (rd_rsp_valid) st <= RD_IDLE;
        default: st <= RD_IDLE;
      endcase
    end
  end

  assign idle         = (st == RD_IDLE);
  assign rd_req_valid = (st == RD_REQ);
  assign rd_addr      = addr_q;
  assign rd_rsp_ready = (st == RD_RSP);
  assign word_vld     = rd_rsp_ready && rd_rsp_valid;
  assign word         = rd_rsp_data;

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_addr)));

  // R7
  one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && rd_req_ready) |=> !rd_req_valid);
endmodule

// File: rtl/blkcmp_cursor.sv
module blkcmp_cursor #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] ld_a,
  input  logic [AW-1:0] ld_b,
  input  logic [CW-1:0] ld_n,
  input  logic          step,
  output logic [AW-1:0] cur_a,
  output logic [AW-1:0] cur_b,
  output logic [CW-1:0] cur_n
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_a <= '0;
      cur_b <= '0;
      cur_n <= '0;
    end else if (load) begin
      cur_a <= ld_a;
      cur_b <= ld_b;
      cur_n <= ld_n;
    end else if (step) begin
      cur_a <= cur_a + AW'(1);
      cur_b <= cur_b + AW'(1);
      cur_n <= cur_n - CW'(1);
    end
  end
endmodule

// File: rtl/blkcmp_seq.sv
module blkcmp_seq
  import blkcmp_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] n_words,
  input  logic          pause_req,
  input  logic [CW-1:0] cur_n,
  input  logic          word_vld,
  input  logic [DW-1:0] word,
  output logic          go,
  output logic          go_sel_b,
  output logic          load,
  output logic          step,
  output logic          busy,
  output logic          done,
  output logic          mismatch,
  output logic          suspended,
  output logic [CW-1:0] remain
);
  seq_state_t st, st_n;
  logic [DW-1:0] word_a_q;
  logic done_n, mism_n, susp_n;
  logic [CW-1:0] rem_n;
  logic last_pair;

  assign last_pair = (cur_n == CW'(1));

  always_comb begin
    st_n     = st;
    go       = 1'b0;
    go_sel_b = 1'b0;
    load     = 1'b0;
    step     = 1'b0;
    done_n   = 1'b0;
    mism_n   = 1'b0;
    susp_n   = 1'b0;
    rem_n    = '0;
    case (st)
      SQ_IDLE: if (start) begin
        if (n_words == '0) begin
          done_n = 1'b1;
        end else begin
          load = 1'b1;
          st_n = SQ_ISSUE_A;
        end
      end
      SQ_ISSUE_A: begin
        go   = 1'b1;
        st_n = SQ_WAIT_A;
      end
      SQ_WAIT_A: if (word_vld) st_n = SQ_ISSUE_B;
      SQ_ISSUE_B: begin
        go       = 1'b1;
        go_sel_b = 1'b1;
        st_n     = SQ_WAIT_B;
      end
      SQ_WAIT_B: if (word_vld) begin
        if (word != word_a_q) begin
          done_n = 1'b1;
          mism_n = 1'b1;
          rem_n  = cur_n;
          st_n   = SQ_IDLE;
        end else begin
          step = 1'b1;
          if (last_pair) begin
            done_n = 1'b1;
            st_n   = SQ_IDLE;
          end else if (pause_req) begin
            susp_n = 1'b1;
            st_n   = SQ_IDLE;
          end else begin
            st_n = SQ_ISSUE_A;
          end
        end
      end
      default: st_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= SQ_IDLE;
      word_a_q  <= '0;
      done      <= 1'b0;
      mismatch  <= 1'b0;
      suspended <= 1'b0;
      remain    <= '0;
    end else begin
      st        <= st_n;
      done      <= done_n;
      mismatch  <= mism_n;
      suspended <= susp_n;
      if (done_n) remain <= rem_n;
      if (st == SQ_WAIT_A && word_vld) word_a_q <= word;
    end
  end

  assign busy = (st != SQ_IDLE);

  // R4
  zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_IDLE && start && n_words == '0) |=> (done && !mismatch && remain == '0));

  // R9
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && suspended));

  // R9
  done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  mism_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |-> done);

  // R2
  clean_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mismatch) |-> (remain == '0));
endmodule

// File: rtl/blkcmp_engine.sv
module blkcmp_engine #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_a,
  input  logic [AW-1:0] base_b,
  input  logic [CW-1:0] n_words,
  input  logic          pause_req,
  output logic          busy,
  output logic          done,
  output logic          mismatch,
  output logic          suspended,
  output logic [CW-1:0] remain,
  output logic [AW-1:0] resume_a,
  output logic [AW-1:0] resume_b,
  output logic [CW-1:0] resume_n,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_rsp_valid,
  output logic          rd_rsp_ready,
  input  logic [DW-1:0] rd_rsp_data
);
  logic go, go_sel_b, load, step, rd_idle, word_vld;
  logic [DW-1:0] word;
  logic [AW-1:0] go_addr;

  blkcmp_cursor #(.AW(AW), .CW(CW)) u_cursor (
    .clk(clk), .rst_n(rst_n), .load(load),
    .ld_a(base_a), .ld_b(base_b), .ld_n(n_words), .step(step),
    .cur_a(resume_a), .cur_b(resume_b), .cur_n(resume_n)
  );

  blkcmp_seq #(.DW(DW), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .n_words(n_words),
    .pause_req(pause_req), .cur_n(resume_n), .word_vld(word_vld), .word(word),
    .go(go), .go_sel_b(go_sel_b), .load(load), .step(step), .busy(busy),
    .done(done), .mismatch(mismatch), .suspended(suspended), .remain(remain)
  );

  assign go_addr = go_sel_b ? resume_b : resume_a;

  blkcmp_reader #(.AW(AW), .DW(DW)) u_reader (
    .clk(clk), .rst_n(rst_n), .go(go), .go_addr(go_addr), .idle(rd_idle),
    .word_vld(word_vld), .word(word),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data)
  );

  // R1
  issue_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> rd_idle);

  // R5
  susp_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> (resume_n != '0));

  // R3
  mism_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mismatch) |-> (remain == resume_n));
endmodule

// File: tb/sim_blkcmp_engine.sv
module sim_blkcmp_engine;
  localparam int AW = 8, DW = 16, CW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, pause_req = 1'b0;
  logic [AW-1:0] base_a = '0, base_b = '0;
  logic [CW-1:0] n_words = '0;
  logic busy, done, mismatch, suspended;
  logic [CW-1:0] remain, resume_n;
  logic [AW-1:0] resume_a, resume_b, rd_addr;
  logic rd_req_valid, rd_rsp_ready;
  logic rd_req_ready = 1'b1, rd_rsp_valid = 1'b0;
  logic [DW-1:0] rd_rsp_data = '0;

  always #5 clk = ~clk;

  blkcmp_engine #(.AW(AW), .DW(DW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .base_a(base_a), .base_b(base_b),
    .n_words(n_words), .pause_req(pause_req), .busy(busy), .done(done),
    .mismatch(mismatch), .suspended(suspended), .remain(remain),
    .resume_a(resume_a), .resume_b(resume_b), .resume_n(resume_n),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data)
  );

  int errors = 0, checks = 0, events = 0;

  // memory model with stalls and variable latency (R7)
  logic [DW-1:0] mem [256];
  logic pend = 1'b0;
  logic [AW-1:0] paddr = '0;
  int lat_cnt = 0, lat_mode = 0, stall_on = 0, tick = 0;

  always @(posedge clk) begin
    tick <= tick + 1;
    if (rd_rsp_valid && rd_rsp_ready) rd_rsp_valid <= 1'b0;
    if (pend) begin
      if (lat_cnt == 0) begin
        rd_rsp_valid <= 1'b1;
        rd_rsp_data  <= mem[paddr];
        pend         <= 1'b0;
      end else lat_cnt <= lat_cnt - 1;
    end
    if (rd_req_valid && rd_req_ready) begin
      pend    <= 1'b1;
      paddr   <= rd_addr;
      lat_cnt <= (lat_mode + tick) % 4 * (lat_mode != 0 ? 1 : 0);
    end
    rd_req_ready <= (stall_on != 0) ? (tick % 3 == 0) : 1'b1;
  end

  typedef struct packed {
    logic          susp;
    logic          mism;
    logic [CW-1:0] rem;
    logic [AW-1:0] ca;
    logic [AW-1:0] cb;
    logic [CW-1:0] cn;
    logic          chk_cur;
  } exp_t;

  exp_t exp_q[$];
  logic [AW-1:0] addr_q[$];
  logic prev_done = 1'b0;

  task automatic fail(string req, string what, int act, int expv);
    errors++;
    $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
  endtask

  // monitor: pops expected reads and results
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_req_valid && rd_req_ready) begin
        checks++;
        if (addr_q.size() == 0) fail("R3", "read after end", int'(rd_addr), -1);
        else begin
          logic [AW-1:0] ea;
          ea = addr_q.pop_front();
          if (rd_addr != ea) fail("R1", "read address", int'(rd_addr), int'(ea));
        end
      end
      if (done && prev_done) begin
        checks++;
        fail("R9", "done wider than one cycle", 2, 1);
      end
      if (done || suspended) begin
        events++;
        checks++;
        if (done && suspended) fail("R9", "done with suspended", 1, 0);
        else if (exp_q.size() == 0) fail("R8", "unexpected completion", 1, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          if (suspended != e.susp) fail(e.susp ? "R5" : "R6", "suspended", int'(suspended), int'(e.susp));
          if (mismatch != e.mism) fail("R3", "mismatch flag", int'(mismatch), int'(e.mism));
          if (done && remain != e.rem) fail(e.mism ? "R3" : "R2", "remain", int'(remain), int'(e.rem));
          if (e.chk_cur) begin
            checks++;
            if (resume_a != e.ca) fail("R5", "resume_a", int'(resume_a), int'(e.ca));
            if (resume_b != e.cb) fail("R5", "resume_b", int'(resume_b), int'(e.cb));
            if (resume_n != e.cn) fail("R5", "resume_n", int'(resume_n), int'(e.cn));
          end
        end
      end
      prev_done <= done;
    end
  end

  task automatic set_runs(int a, int b, int n, int k);
    for (int j = 0; j < n; j++) mem[(b + j) % 256] = mem[(a + j) % 256];
    if (k < n) mem[(b + k) % 256] = mem[(b + k) % 256] ^ 16'h0100;
  endtask

  // driver: computes expected outcome, pushes it, runs one compare
  task automatic run_one(int a, int b, int n, bit poke, output bit was_susp);
    exp_t e;
    int k, last, ev0;
    k = n;
    for (int j = 0; j < n; j++)
      if (k == n && mem[(a + j) % 256] != mem[(b + j) % 256]) k = j;
    if (pause_req && k > 0 && n > 1) last = 0;
    else last = (k < n) ? k : n - 1;
    for (int j = 0; j <= last && n > 0; j++) begin
      addr_q.push_back(AW'(a + j));
      addr_q.push_back(AW'(b + j));
    end
    e = '0;
    e.chk_cur = (n != 0);
    if (pause_req && k > 0 && n > 1) begin
      e.susp = 1'b1;
      e.ca = AW'(a + 1); e.cb = AW'(b + 1); e.cn = CW'(n - 1);
    end else if (k < n) begin
      e.mism = 1'b1; e.rem = CW'(n - k);
      e.ca = AW'(a + k); e.cb = AW'(b + k); e.cn = CW'(n - k);
    end else begin
      e.ca = AW'(a + n); e.cb = AW'(b + n); e.cn = '0;
    end
    exp_q.push_back(e);
    was_susp = e.susp;
    while (busy) @(negedge clk);
    ev0 = events;
    base_a = AW'(a); base_b = AW'(b); n_words = CW'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (n == 0) begin
      checks++;
      if (!done) fail("R4", "done one cycle after zero-count start", int'(done), 1);
    end
    if (poke) begin
      repeat (3) @(negedge clk);
      base_a = 8'hF0; n_words = '0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (events == ev0) @(negedge clk);
    @(negedge clk);
    checks++;
    if (addr_q.size() != 0) fail("R1", "reads missing", addr_q.size(), 0);
    addr_q.delete();
  endtask

  task automatic run_chain(int a, int b, int n);
    bit s;
    run_one(a, b, n, 1'b0, s);
    while (s) run_one(int'(resume_a), int'(resume_b), int'(resume_n), 1'b0, s);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = DW'(i * 37 + 5);
    #10000000;
    fail("R9", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    bit s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (busy || done || suspended || rd_req_valid)
      fail("R9", "reset state", int'({busy, done, suspended, rd_req_valid}), 0);

    // R2: equal runs, no stalls
    set_runs(16, 64, 5, 99);
    run_one(16, 64, 5, 1'b0, s);
    // R3: mismatch mid-run, with stalls and latency (R7)
    stall_on = 1; lat_mode = 2;
    set_runs(16, 64, 8, 3);
    run_one(16, 64, 8, 1'b0, s);
    // R3: mismatch on first pair
    set_runs(20, 100, 6, 0);
    run_one(20, 100, 6, 1'b0, s);
    // R3: mismatch on last pair
    lat_mode = 3;
    set_runs(30, 120, 7, 6);
    run_one(30, 120, 7, 1'b0, s);
    // R4: zero count
    run_one(30, 120, 0, 1'b0, s);
    // R2: single equal pair
    stall_on = 0; lat_mode = 0;
    set_runs(40, 140, 1, 99);
    run_one(40, 140, 1, 1'b0, s);
    // R8: start while busy ignored
    lat_mode = 1;
    set_runs(50, 150, 6, 4);
    run_one(50, 150, 6, 1'b1, s);
    // R5/R6: held pause, resumed until mismatch
    pause_req = 1'b1; stall_on = 1;
    set_runs(60, 160, 7, 4);
    run_chain(60, 160, 7);
    // R5/R6: held pause, equal runs finish on last pair
    set_runs(70, 170, 3, 99);
    run_chain(70, 170, 3);
    pause_req = 1'b0;
    // R2: run compared with itself, wrapping address
    run_one(250, 250, 10, 1'b0, s);
    // R5: suspend then resume with pause released
    pause_req = 1'b1;
    set_runs(80, 180, 9, 5);
    run_one(80, 180, 9, 1'b0, s);
    pause_req = 1'b0;
    run_one(int'(resume_a), int'(resume_b), int'(resume_n), 1'b0, s);

    checks++;
    if (exp_q.size() != 0) fail("R2", "completions missing", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule